// File: doc/BRIEF.md
# Calibrated Double-Buffered DAC Register Bank

This block is the digital register core behind a multi-channel 14-bit digital-to-analog converter. Every channel keeps a gain register and an offset register. A code written to a channel does not go straight to the converter: a shared correction engine first scales it by the channel's gain, adds the channel's offset and clamps the result. The corrected value then waits in a staging register until a load request copies the staged values of all channels into their DAC registers in one clock edge. The engine works one multiplier bit per cycle and raises `busy` for the whole computation. A load request that arrives during a computation is remembered and carried out once the computation is done.

A global clear input forces every DAC register to a programmable clear code at once. A channel can be put into toggle mode, where it keeps two staged codes and each transfer moves it to the other one, which produces a square wave at the converter. A small control register holds three analog option bits (output boost, internal reference enable, reference level select) and drives them out as pins.

Top module: `caldac_bank`

## Requirements
- R1: After reset `busy` is 0, every DAC code is 0, the clear code is 0, the control outputs are 0, every gain register holds all ones and every offset register holds 2^(DW-1), so that a correction leaves a code unchanged.
- R2: A write with `wr_sel` = 0 (primary data) to channel `wr_ch` stages y = floor(x·(m+1)/2^DW) + c − 2^(DW-1), where x is `wr_data`, m is the channel gain (written with `wr_sel` = 2) and c is the channel offset (written with `wr_sel` = 3), both taken as held before the data write edge.
- R3: The corrected value saturates: a negative y stages 0 and a y above 2^DW − 1 stages 2^DW − 1.
- R4: A data write accepted while `busy` is 0 raises `busy` on the next edge and `busy` stays high for exactly DW+2 cycles.
- R5: A data write made while `busy` is 1 is dropped and stages nothing.
- R6: DAC codes change only on a transfer or a clear; a transfer copies the staged values of all channels on the same edge, and channel k appears on `dac_codes[k*DW +: DW]`.
- R7: A `load` seen high while `busy` is 1 is held pending; the transfer happens on the first edge at which `busy` is 0, i.e. one cycle after `busy` falls.
- R8: With `load` held high, a newly corrected value reaches the DAC register one cycle after `busy` falls.
- R9: While `clr` is high, every DAC register loads the clear code (written with `wr_sel` = 4) on each edge, taking priority over a transfer in the same cycle.
- R10: A `clr` cancels a pending load request, so the DAC codes keep the clear code after the running computation ends.
- R11: Writing `wr_sel` = 6 with `wr_data[0]` = 1 puts the channel in toggle mode and resets its phase; `wr_sel` = 1 stages a corrected secondary code. In toggle mode successive transfers load primary, secondary, primary, …; with bit 0 = 0 a transfer loads the primary code.
- R12: A write with `wr_sel` = 5 sets `boost_en` from `wr_data[0]`, `ref_en` from `wr_data[1]` and `ref_hi` from `wr_data[2]`, visible after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Target register select |
| wr_ch | input | CHW | Channel index of the write |
| wr_data | input | DW | Write data |
| load | input | 1 | Transfer staged codes to all DAC registers |
| clr | input | 1 | Force all DAC registers to the clear code |
| busy | output | 1 | Correction engine running |
| dac_codes | output | NCH*DW | DAC register contents, channel k at bits k*DW upward |
| boost_en | output | 1 | Output amplifier boost option |
| ref_en | output | 1 | Internal reference enable option |
| ref_hi | output | 1 | High reference level select |

## Verification
The bench aims at the edges of the correction: identity calibration after reset, a fractional gain whose product must be floored, and offsets that push the result past both rails, where a design that wrapped instead of clamping would show a small code near the opposite end. It times the load handshake cycle by cycle: a design that acted on a load during `busy` would copy a stale staged value, and one that forgot the request would never update. It checks that a clear beats a simultaneous load and cancels a pending one, that a second write during `busy` does not replace the first, and that toggle mode walks its two codes in the right order rather than starting on the secondary one.

// File: rtl/caldac_pkg.sv
package caldac_pkg;

   // Register select codes of the write port
   typedef enum logic [2:0] {
      SEL_DATA_A  = 3'd0,
      SEL_DATA_B  = 3'd1,
      SEL_GAIN    = 3'd2,
      SEL_OFFSET  = 3'd3,
      SEL_CLRCODE = 3'd4,
      SEL_CTRL    = 3'd5,
      SEL_TOGGLE  = 3'd6,
      SEL_NONE    = 3'd7
   } wsel_e;

   // Analog option bits, bit 0 = boost
   typedef struct packed {
      logic ref_hi;
      logic ref_en;
      logic boost;
   } ctrl_t;

endpackage

// File: rtl/caldac_engine.sv
module caldac_engine #(
   parameter int DW  = 14,
   parameter int CHW = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [DW-1:0]  x,
   input  logic [DW-1:0]  m,
   input  logic [DW-1:0]  c,
   input  logic [CHW-1:0] ch_in,
   input  logic           slot_in,
   output logic           busy,
   output logic           done,
   output logic [DW-1:0]  result,
   output logic [CHW-1:0] done_ch,
   output logic           done_slot
);
   localparam int MW = DW + 1;             // multiplier (m+1) width
   localparam int CW = $clog2(MW + 1);
   localparam int SW = DW + 2;             // signed sum width
   localparam logic [CW-1:0] LAST   = CW'(MW);
   localparam logic [CW-1:0] NSHIFT = CW'(DW);
   localparam logic [SW-1:0] HALF   = SW'(1) << (DW - 1);

   logic           busy_q;
   logic [CW-1:0]  cnt_q;
   logic [DW:0]    acc_q;
   logic [DW-1:0]  x_q;
   logic [MW-1:0]  mplier_q;
   logic [DW-1:0]  c_q;
   logic [CHW-1:0] ch_q;
   logic           slot_q;

   logic [DW:0]    sum;
   logic signed [SW-1:0] s_w;

   // shift-right accumulation keeps the running product already divided by 2^k
   assign sum = acc_q + (mplier_q[0] ? {1'b0, x_q} : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         cnt_q    <= '0;
         acc_q    <= '0;
         x_q      <= '0;
         mplier_q <= '0;
         c_q      <= '0;
         ch_q     <= '0;
         slot_q   <= 1'b0;
      end else if (!busy_q) begin
         if (start) begin
            busy_q   <= 1'b1;
            cnt_q    <= '0;
            acc_q    <= '0;
            x_q      <= x;
            mplier_q <= {1'b0, m} + MW'(1);
            c_q      <= c;
            ch_q     <= ch_in;
            slot_q   <= slot_in;
         end
      end else if (cnt_q == LAST) begin
         busy_q <= 1'b0;
      end else begin
         acc_q    <= (cnt_q < NSHIFT) ? (sum >> 1) : sum;
         mplier_q <= mplier_q >> 1;
         cnt_q    <= cnt_q + CW'(1);
      end
   end

   assign s_w = $signed({2'b00, acc_q[DW-1:0]}) + $signed({2'b00, c_q}) - $signed(HALF);

   always_comb begin
      if (s_w[SW-1])
         result = '0;
      else if (s_w[DW])
         result = '1;
      else
         result = s_w[DW-1:0];
   end

   assign busy      = busy_q;
   assign done      = busy_q && (cnt_q == LAST);
   assign done_ch   = ch_q;
   assign done_slot = slot_q;

endmodule

// File: rtl/caldac_channel.sv
module caldac_channel #(
   parameter int DW = 14
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          gain_we,
   input  logic          offs_we,
   input  logic          tog_we,
   input  logic [DW-1:0] wdata,
   input  logic          stage_we,
   input  logic          stage_slot,
   input  logic [DW-1:0] stage_val,
   input  logic          xfer,
   input  logic          clr,
   input  logic [DW-1:0] clr_code,
   output logic [DW-1:0] gain,
   output logic [DW-1:0] offs,
   output logic [DW-1:0] dac
);
   localparam logic [DW-1:0] OFFS_RST = DW'(1) << (DW - 1);

   logic [DW-1:0] gain_q, offs_q, sa_q, sb_q, dac_q;
   logic          tog_q, ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gain_q <= '1;
         offs_q <= OFFS_RST;
      end else begin
         if (gain_we) gain_q <= wdata;
         if (offs_we) offs_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sa_q <= '0;
         sb_q <= '0;
      end else if (stage_we) begin
         if (stage_slot) sb_q <= stage_val;
         else            sa_q <= stage_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dac_q <= '0;
         tog_q <= 1'b0;
         ph_q  <= 1'b0;
      end else begin
         if (tog_we) begin
            tog_q <= wdata[0];
            ph_q  <= 1'b0;
         end
         if (clr) begin
            dac_q <= clr_code;
         end else if (xfer) begin
            if (tog_q) begin
               dac_q <= ph_q ? sb_q : sa_q;
               if (!tog_we) ph_q <= ~ph_q;
            end else begin
               dac_q <= sa_q;
            end
         end
      end
   end

   assign gain = gain_q;
   assign offs = offs_q;
   assign dac  = dac_q;

endmodule

// File: rtl/caldac_loadctl.sv
module caldac_loadctl (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic clr,
   input  logic busy,
   output logic xfer,
   output logic pend
);
   logic pend_q;

   assign xfer = !clr && !busy && (load || pend_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= 1'b0;
      else if (clr || xfer)
         pend_q <= 1'b0;
      else if (load && busy)
         pend_q <= 1'b1;
   end

   assign pend = pend_q;

endmodule

// File: rtl/caldac_bank.sv
module caldac_bank
   import caldac_pkg::*;
#(
   parameter int NCH = 4,
   parameter int DW  = 14,
   parameter int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [CHW-1:0]    wr_ch,
   input  logic [DW-1:0]     wr_data,
   input  logic              load,
   input  logic              clr,
   output logic              busy,
   output logic [NCH*DW-1:0] dac_codes,
   output logic              boost_en,
   output logic              ref_en,
   output logic              ref_hi
);
   // elaboration checks
   if (NCH < 1) begin : g_bad_nch
      $error("caldac_bank: NCH must be at least 1");
   end
   if (DW < 4 || DW > 24) begin : g_bad_dw
      $error("caldac_bank: DW must lie in 4..24");
   end
   if ((1 << CHW) < NCH) begin : g_bad_chw
      $error("caldac_bank: CHW too narrow for NCH");
   end

   wsel_e          sel;
   logic           ch_ok;
   logic           data_wr;
   logic           start;
   logic           done;
   logic [DW-1:0]  result;
   logic [CHW-1:0] done_ch;
   logic           done_slot;
   logic           xfer;
   logic           pend;
   logic [DW-1:0]  clr_code_q;
   ctrl_t          ctrl_q;

   logic [DW-1:0]  gain_arr [NCH];
   logic [DW-1:0]  offs_arr [NCH];
   logic [DW-1:0]  dac_arr  [NCH];

   assign sel     = wsel_e'(wr_sel);
   assign ch_ok   = ({1'b0, wr_ch} < (CHW+1)'(NCH));
   assign data_wr = wr_en && ch_ok && (sel == SEL_DATA_A || sel == SEL_DATA_B);
   assign start   = data_wr && !busy;

   caldac_engine #(.DW(DW), .CHW(CHW)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .x         (wr_data),
      .m         (gain_arr[wr_ch]),
      .c         (offs_arr[wr_ch]),
      .ch_in     (wr_ch),
      .slot_in   (sel == SEL_DATA_B),
      .busy      (busy),
      .done      (done),
      .result    (result),
      .done_ch   (done_ch),
      .done_slot (done_slot)
   );

   caldac_loadctl u_ldc (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .clr   (clr),
      .busy  (busy),
      .xfer  (xfer),
      .pend  (pend)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clr_code_q <= '0;
         ctrl_q     <= '0;
      end else if (wr_en) begin
         if (sel == SEL_CLRCODE) clr_code_q <= wr_data;
         if (sel == SEL_CTRL)    ctrl_q     <= ctrl_t'(wr_data[2:0]);
      end
   end

   for (genvar k = 0; k < NCH; k++) begin : g_ch
      logic hit;
      assign hit = wr_en && (wr_ch == CHW'(k));

      caldac_channel #(.DW(DW)) u_ch (
         .clk        (clk),
         .rst_n      (rst_n),
         .gain_we    (hit && sel == SEL_GAIN),
         .offs_we    (hit && sel == SEL_OFFSET),
         .tog_we     (hit && sel == SEL_TOGGLE),
         .wdata      (wr_data),
         .stage_we   (done && done_ch == CHW'(k)),
         .stage_slot (done_slot),
         .stage_val  (result),
         .xfer       (xfer),
         .clr        (clr),
         .clr_code   (clr_code_q),
         .gain       (gain_arr[k]),
         .offs       (offs_arr[k]),
         .dac        (dac_arr[k])
      );

      assign dac_codes[k*DW +: DW] = dac_arr[k];
   end

   assign boost_en = ctrl_q.boost;
   assign ref_en   = ctrl_q.ref_en;
   assign ref_hi   = ctrl_q.ref_hi;

endmodule

// File: rtl/caldac_bank_chk.sv
module caldac_bank_chk #(
   parameter int NCH = 4,
   parameter int DW  = 14,
   parameter int CHW = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [2:0]        wr_sel,
   input logic [CHW-1:0]    wr_ch,
   input logic              load,
   input logic              clr,
   input logic              busy,
   input logic [NCH*DW-1:0] dac_codes,
   input logic [DW-1:0]     clr_code,
   input logic              pend
);
   localparam int RW = $clog2(DW + 3) + 1;

   logic [RW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_q <= '0;
      else if (busy) run_q <= run_q + RW'(1);
      else           run_q <= '0;
   end

   // R4: an accepted data write starts the engine
   assert_busy_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !busy && (wr_sel == 3'd0 || wr_sel == 3'd1) && ({1'b0, wr_ch} < (CHW+1)'(NCH)))
      |=> busy);

   // R4: busy lasts exactly DW+2 cycles
   assert_busy_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && run_q != '0) |-> (run_q == RW'(DW + 2)));

   // R6 and R7: no transfer while the engine runs
   assert_hold_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !clr) |=> $stable(dac_codes));

   // R7: load during busy is remembered
   assert_defer_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (load && busy && !clr) |=> pend);

   // R9: clear loads the clear code everywhere
   assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (dac_codes == $past({NCH{clr_code}})));

   // R10: clear drops a pending request
   assert_clr_cancel_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !pend);

endmodule

bind caldac_bank caldac_bank_chk #(.NCH(NCH), .DW(DW), .CHW(CHW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_sel    (wr_sel),
   .wr_ch     (wr_ch),
   .load      (load),
   .clr       (clr),
   .busy      (busy),
   .dac_codes (dac_codes),
   .clr_code  (clr_code_q),
   .pend      (pend)
);

// File: tb/sim_caldac_bank.sv
`timescale 1ns/1ps
module sim_caldac_bank;
   localparam int NCH = 4;
   localparam int DW  = 14;
   localparam int CHW = 2;
   localparam int HALF = 1 << (DW - 1);
   localparam int MAXC = (1 << DW) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [2:0]        wr_sel = '0;
   logic [CHW-1:0]    wr_ch = '0;
   logic [DW-1:0]     wr_data = '0;
   logic              load = 1'b0;
   logic              clr = 1'b0;
   logic              busy;
   logic [NCH*DW-1:0] dac_codes;
   logic              boost_en, ref_en, ref_hi;

   int checks = 0;
   int errors = 0;
   bit summary_done = 0;

   always #2 clk = ~clk;   // 250 MHz

   caldac_bank #(.NCH(NCH), .DW(DW), .CHW(CHW)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_ch(wr_ch),
      .wr_data(wr_data), .load(load), .clr(clr), .busy(busy),
      .dac_codes(dac_codes), .boost_en(boost_en), .ref_en(ref_en), .ref_hi(ref_hi)
   );

   function automatic int dac(int k);
      return int'(dac_codes[k*DW +: DW]);
   endfunction

   function automatic int corr(int x, int m, int c);
      int y;
      y = ((x * (m + 1)) >>> DW) + c - HALF;
      if (y < 0) y = 0;
      if (y > MAXC) y = MAXC;
      return y;
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(int sel, int ch, int data);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 3'(sel); wr_ch = CHW'(ch); wr_data = DW'(data);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 100 && busy; i++) @(negedge clk);
   endtask

   task automatic pulse_load();
      @(negedge clk); load = 1'b1;
      @(negedge clk); load = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 busy", int'(busy), 0);
      for (int k = 0; k < NCH; k++) chk("R1 dac", dac(k), 0);
      chk("R1 ctrl", int'({ref_hi, ref_en, boost_en}), 0);
   endtask

   task automatic t_identity();
      int n = 0;
      wr(0, 0, 1234);
      chk("R4 busy raised", int'(busy), 1);
      while (busy && n < 100) begin n++; @(negedge clk); end
      chk("R4 busy length", n, DW + 2);
      chk("R6 no update without load", dac(0), 0);
      pulse_load();
      chk("R2 identity ch0", dac(0), 1234);
      wr(0, 3, 777); wait_idle();
      wr(0, 2, 55);  wait_idle();
      chk("R6 ch3 waits", dac(3), 0);
      chk("R6 ch2 waits", dac(2), 0);
      pulse_load();
      chk("R6 ch3 joint", dac(3), 777);
      chk("R6 ch2 joint", dac(2), 55);
   endtask

   task automatic t_gain();
      wr(2, 1, 12000); wr(3, 1, 8000);
      wr(0, 1, 3333); wait_idle(); pulse_load();
      chk("R2 gain/offset a", dac(1), corr(3333, 12000, 8000));
      wr(2, 1, 8191); wr(3, 1, 8292);
      wr(0, 1, 10000); wait_idle(); pulse_load();
      chk("R2 gain/offset b", dac(1), 5100);
   endtask

   task automatic t_sat();
      wr(3, 2, MAXC); wr(0, 2, MAXC); wait_idle(); pulse_load();
      chk("R3 clamp high", dac(2), MAXC);
      wr(3, 2, 0); wr(0, 2, 100); wait_idle(); pulse_load();
      chk("R3 clamp low", dac(2), 0);
   endtask

   task automatic t_drop();
      wr(0, 3, 500);
      wr(0, 3, 900);
      wait_idle(); pulse_load();
      chk("R5 write during busy dropped", dac(3), 500);
   endtask

   task automatic t_defer();
      bit held = 1;
      wr(0, 0, 4000);
      load = 1'b1;
      @(negedge clk); load = 1'b0;
      while (busy) begin
         if (dac(0) != 1234) held = 0;
         @(negedge clk);
      end
      chk("R7 held while busy", int'(held), 1);
      chk("R7 not yet at busy fall", dac(0), 1234);
      @(negedge clk);
      chk("R7 deferred transfer", dac(0), 4000);
   endtask

   task automatic t_tied();
      load = 1'b1;
      wr(0, 1, 6000);
      wait_idle();
      chk("R8 old at busy fall", dac(1), 5100);
      @(negedge clk);
      chk("R8 new after busy fall", dac(1), corr(6000, 8191, 8292));
      load = 1'b0;
   endtask

   task automatic t_clear();
      wr(4, 0, 4321);
      @(negedge clk); clr = 1'b1; load = 1'b1;
      @(negedge clk); clr = 1'b0; load = 1'b0;
      for (int k = 0; k < NCH; k++) chk("R9 clear code", dac(k), 4321);
   endtask

   task automatic t_cancel();
      wr(0, 2, 9000);
      load = 1'b1;
      @(negedge clk); load = 1'b0; clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      wait_idle();
      repeat (3) @(negedge clk);
      chk("R10 pending cancelled", dac(2), 4321);
      pulse_load();
      chk("R10 staged intact", dac(2), corr(9000, MAXC, 0));
   endtask

   task automatic t_toggle();
      wr(6, 0, 1);
      wr(0, 0, 100); wait_idle();
      wr(1, 0, 200); wait_idle();
      pulse_load(); chk("R11 toggle first primary", dac(0), 100);
      pulse_load(); chk("R11 toggle secondary", dac(0), 200);
      pulse_load(); chk("R11 toggle back", dac(0), 100);
      wr(6, 0, 0);
      pulse_load(); chk("R11 toggle off", dac(0), 100);
   endtask

   task automatic t_ctrl();
      wr(5, 0, 5);
      chk("R12 ctrl 101", int'({ref_hi, ref_en, boost_en}), 5);
      wr(5, 0, 2);
      chk("R12 ctrl 010", int'({ref_hi, ref_en, boost_en}), 2);
   endtask

   task automatic finish_run();
      if (!summary_done) begin
         summary_done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(4 * 200000);
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_identity();
      t_gain();
      t_sat();
      t_drop();
      t_defer();
      t_tied();
      t_clear();
      t_cancel();
      t_toggle();
      t_ctrl();
      finish_run();
   end

endmodule